// File: doc/BRIEF.md
# Cold and Warm Reset Sequencer

This block turns two active-low reset sources into a set of domain resets with different sensitivities. A power-on input starts a cold reset, which clears every domain it owns and all of its own settings. A low level seen on the shared external reset pin starts a warm reset, which clears only the warm-resettable system domain. The test-access reset is driven only by its own dedicated input. The debug domain and the cold-only system domain respond to cold reset alone.

On every reset episode the block drives the external pin low for a programmed number of cycles. This lets it reset devices on the board. The pin is modelled as an output enable plus the level read back from the pad. The block ignores the level on the pin while it is driving the pin and for a short guard window after it lets go, so its own pulse cannot start a new warm reset.

During a warm reset the block raises safe-mode requests toward the clock controller: one for the main clocks and one for the debug clocks. A set of control bits can suppress these requests. Those bits and the pulse length are cleared only by cold reset, so they survive any number of warm resets.

Top module: `rst_seq_top`

## Requirements
- R1: While `porN` is low, `debugRstN`, `coldSysRstN` and `warmSysRstN` are low and `pinOe` is high, and this takes effect without waiting for a clock edge. Release of `porN` passes through a two-flop synchronizer.
- R2: Cold reset clears `cfgFlagsOut` to 0 and sets `cfgCountOut` to the default of 2048.
- R3: When the synchronized pin level is low and the block is idle, `pinOe` goes high for exactly N cycles, where N is `cfgCountOut`. A count of 0 gives a 1-cycle pulse.
- R4: `warmSysRstN` goes low with the pulse. It stays low until at least one cycle after `pinOe` falls (N plus 3 guard cycles in total), then returns high.
- R5: A warm reset leaves `debugRstN` and `coldSysRstN` high.
- R6: `tapRstN` follows only `testRstN`. It drops asynchronously when `testRstN` goes low, and neither `porN` nor warm reset affects it.
- R7: Pin sampling is masked while `pinOe` is high and for 2 cycles after the pin-level synchronizer can see the release. The block's own pulse never starts another warm reset.
- R8: A cycle with `cfgWrEn` high loads `cfgFlagsIn` and `cfgCountIn`, and the new values are visible on the next cycle. The flag bits are: bit0 main safe-mode off, bit1 debug safe-mode off, bit2 debug clock on oscillator, bit3 boot from RAM. Warm reset changes neither the flags nor the count.
- R9: `safeReqMain` is high during a warm reset unless flag bit0 is set. It is never high outside a warm reset.
- R10: `safeReqDebug` is high during a warm reset unless flag bit1 is set and flag bit2 is clear. Setting bit2 cancels bit1.
- R11: A cold reset that arrives during a warm pulse takes over. After `porN` is released, the pin pulse restarts with the default count of 2048 cycles. The cold domains stay low until that pulse and its guard window end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Active-low power-on (cold) reset |
| testRstN | input | 1 | Active-low dedicated test-access reset |
| pinIn | input | 1 | Level read back from the external reset pin |
| cfgWrEn | input | 1 | Write strobe for flags and count |
| cfgFlagsIn | input | 4 | New control flag values |
| cfgCountIn | input | CNT_W | New pin pulse length in cycles |
| pinOe | output | 1 | Drive the external pin low when high |
| tapRstN | output | 1 | Test-access domain reset, active low |
| debugRstN | output | 1 | Debug domain reset, active low |
| coldSysRstN | output | 1 | Cold-only system domain reset, active low |
| warmSysRstN | output | 1 | Warm-resettable system domain reset, active low |
| safeReqMain | output | 1 | Safe-mode request for the main clocks |
| safeReqDebug | output | 1 | Safe-mode request for the debug clocks |
| cfgFlagsOut | output | 4 | Current control flags |
| cfgCountOut | output | CNT_W | Current pin pulse length |

## Verification
Some properties are checked on every cycle:
- the pulse counter steps down by exactly one;
- the flags and count hold steady when no write is made;
- the warm domain reset is still low in the cycle the pin is released;
- the pin is not driven again in the cycle right after release;
- a main-clock safe-mode request never appears outside a warm reset.

Other behaviour can only be shown by the bench's scenarios. This covers the exact pulse lengths, the flag combinations that decide the two safe-mode requests, and the survival of the settings through warm resets. It also covers the immunity of the debug, cold-only and test domains, and the cold reset that takes over in the middle of a warm pulse and restarts it at 2048 cycles.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int FLAG_W = 4;
  localparam int F_SAFE_OFF = 0;
  localparam int F_DBG_SAFE_OFF = 1;
  localparam int F_DBG_ON_OSC = 2;
  localparam int F_BOOT_RAM = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_PULSE, ST_GUARD} rsState_e;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
  } rsStrobe_s;
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arstN,
  output logic rstOutN
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rstOutN = chain[STAGES-1];
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DEF_COUNT = 2048
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  rsStrobe_s         strobe,
  input  logic              cfgWrEn,
  input  logic [FLAG_W-1:0] cfgFlagsIn,
  input  logic [CNT_W-1:0]  cfgCountIn,
  output logic              cntZero,
  output logic [FLAG_W-1:0] flags,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] DEF_CNT = CNT_W'(DEF_COUNT);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  // Settings: cleared by cold reset only.
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      flags <= '0;
      count <= DEF_CNT;
    end else if (cfgWrEn) begin
      flags <= cfgFlagsIn;
      count <= cfgCountIn;
    end
  end

  // Pulse counter: holds remaining cycles minus one.
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN)          cnt <= DEF_CNT - ONE;
    else if (strobe.loadCnt) cnt <= (count == '0) ? '0 : count - ONE;
    else if (strobe.decCnt)  cnt <= cnt - ONE;
  end

  assign cntZero = (cnt == '0);

  a_r3_count_steps: assert property (@(posedge clk) disable iff (!coldRstN)
    (strobe.decCnt && !strobe.loadCnt) |=> (cnt == $past(cnt) - ONE));

  a_r8_settings_hold: assert property (@(posedge clk) disable iff (!coldRstN)
    !cfgWrEn |=> ($stable(flags) && $stable(count)));
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int MASK_CYC = 2
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              pinIn,
  input  logic              cntZero,
  input  logic [FLAG_W-1:0] flags,
  output rsStrobe_s         strobe,
  output logic              pinOe,
  output logic              warmSysRstN,
  output logic              coldDomRstN,
  output logic              safeReqMain,
  output logic              safeReqDebug
);
  localparam int GUARD_LEN = MASK_CYC + 1;
  localparam int GUARD_W = $clog2(GUARD_LEN + 1);
  localparam logic [GUARD_W-1:0] GUARD_INIT = GUARD_W'(GUARD_LEN - 1);

  rsState_e state;
  logic fromCold;
  logic pinMeta, pinSync;
  logic [GUARD_W-1:0] guardCnt;
  logic trigger, warmEpisode;

  assign trigger = (state == ST_IDLE) && !pinSync;

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      state    <= ST_PULSE;
      fromCold <= 1'b1;
      guardCnt <= '0;
      pinMeta  <= 1'b1;
      pinSync  <= 1'b1;
    end else begin
      pinMeta <= pinIn;
      pinSync <= pinMeta;
      case (state)
        ST_IDLE: if (trigger) begin
          state    <= ST_PULSE;
          fromCold <= 1'b0;
        end
        ST_PULSE: if (cntZero) begin
          state    <= ST_GUARD;
          guardCnt <= GUARD_INIT;
        end
        ST_GUARD: begin
          if (guardCnt == '0) state <= ST_IDLE;
          else                guardCnt <= guardCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadCnt = trigger;
    strobe.decCnt  = (state == ST_PULSE) && !cntZero;
  end

  assign pinOe       = (state == ST_PULSE);
  assign warmSysRstN = coldRstN && (state == ST_IDLE);
  assign coldDomRstN = coldRstN && !(fromCold && (state != ST_IDLE));
  assign warmEpisode = coldRstN && !fromCold && (state != ST_IDLE);
  assign safeReqMain = warmEpisode && !flags[F_SAFE_OFF];
  assign safeReqDebug = warmEpisode &&
                        (flags[F_DBG_ON_OSC] || !flags[F_DBG_SAFE_OFF]);

  a_r4_held_past_pin: assert property (@(posedge clk) disable iff (!coldRstN)
    $fell(pinOe) |-> !warmSysRstN);

  a_r7_no_redrive: assert property (@(posedge clk) disable iff (!coldRstN)
    $fell(pinOe) |=> !pinOe);

  a_r9_safe_only_warm: assert property (@(posedge clk) disable iff (!coldRstN)
    safeReqMain |-> (!warmSysRstN && coldDomRstN));
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rs_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DEF_COUNT = 2048,
  parameter int MASK_CYC = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              testRstN,
  input  logic              pinIn,
  input  logic              cfgWrEn,
  input  logic [FLAG_W-1:0] cfgFlagsIn,
  input  logic [CNT_W-1:0]  cfgCountIn,
  output logic              pinOe,
  output logic              tapRstN,
  output logic              debugRstN,
  output logic              coldSysRstN,
  output logic              warmSysRstN,
  output logic              safeReqMain,
  output logic              safeReqDebug,
  output logic [FLAG_W-1:0] cfgFlagsOut,
  output logic [CNT_W-1:0]  cfgCountOut
);
  logic coldRstN, cntZero, coldDomRstN;
  rsStrobe_s strobe;

  rs_sync #(.STAGES(SYNC_STAGES)) uColdSync (
    .clk(clk), .arstN(porN), .rstOutN(coldRstN));

  rs_sync #(.STAGES(SYNC_STAGES)) uTapSync (
    .clk(clk), .arstN(testRstN), .rstOutN(tapRstN));

  rs_ctrl #(.MASK_CYC(MASK_CYC)) uCtrl (
    .clk(clk), .coldRstN(coldRstN), .pinIn(pinIn), .cntZero(cntZero),
    .flags(cfgFlagsOut), .strobe(strobe), .pinOe(pinOe),
    .warmSysRstN(warmSysRstN), .coldDomRstN(coldDomRstN),
    .safeReqMain(safeReqMain), .safeReqDebug(safeReqDebug));

  rs_datapath #(.CNT_W(CNT_W), .DEF_COUNT(DEF_COUNT)) uData (
    .clk(clk), .coldRstN(coldRstN), .strobe(strobe), .cfgWrEn(cfgWrEn),
    .cfgFlagsIn(cfgFlagsIn), .cfgCountIn(cfgCountIn), .cntZero(cntZero),
    .flags(cfgFlagsOut), .count(cfgCountOut));

  // Debug and cold-only system domains share the cold-only reset source.
  assign debugRstN   = coldDomRstN;
  assign coldSysRstN = coldDomRstN;
endmodule

// File: tb/tb_rst_seq_top.sv
module tb_rst_seq_top;
  localparam int CNT_W = 12;
  localparam int DEF = 2048;

  logic clk = 1'b0;
  logic porN = 1'b0, testRstN = 1'b0, extLow = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [3:0] cfgFlagsIn = '0;
  logic [CNT_W-1:0] cfgCountIn = '0;
  logic pinIn, pinOe, tapRstN, debugRstN, coldSysRstN, warmSysRstN;
  logic safeReqMain, safeReqDebug;
  logic [3:0] cfgFlagsOut;
  logic [CNT_W-1:0] cfgCountOut;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign pinIn = !(pinOe || extLow);

  rst_seq_top dut (
    .clk(clk), .porN(porN), .testRstN(testRstN), .pinIn(pinIn),
    .cfgWrEn(cfgWrEn), .cfgFlagsIn(cfgFlagsIn), .cfgCountIn(cfgCountIn),
    .pinOe(pinOe), .tapRstN(tapRstN), .debugRstN(debugRstN),
    .coldSysRstN(coldSysRstN), .warmSysRstN(warmSysRstN),
    .safeReqMain(safeReqMain), .safeReqDebug(safeReqDebug),
    .cfgFlagsOut(cfgFlagsOut), .cfgCountOut(cfgCountOut));

  // flags, count, expected main request, expected debug request
  localparam logic [17:0] VEC [0:6] = '{
    {4'b0000, 12'd5, 1'b1, 1'b1},
    {4'b0001, 12'd7, 1'b0, 1'b1},
    {4'b0010, 12'd4, 1'b1, 1'b0},
    {4'b0110, 12'd3, 1'b1, 1'b1},
    {4'b0011, 12'd9, 1'b0, 1'b0},
    {4'b1000, 12'd0, 1'b1, 1'b1},
    {4'b0111, 12'd6, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [3:0] f, input logic [CNT_W-1:0] c);
    cfgFlagsIn = f; cfgCountIn = c; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Request a warm reset from outside and measure the pin pulse.
  task automatic warmRun(output int len, output bit sawMain, output bit sawDbg,
                         output bit coldDomOk, output bit heldPast);
    int w = 0;
    sawMain = 0; sawDbg = 0; coldDomOk = 1; len = 0;
    extLow = 1'b1;
    repeat (2) @(negedge clk);
    extLow = 1'b0;
    while (!pinOe && w < 50) begin @(negedge clk); w++; end
    while (pinOe && len < 5000) begin
      len++;
      sawMain |= safeReqMain;
      sawDbg  |= safeReqDebug;
      if (!debugRstN || !coldSysRstN) coldDomOk = 0;
      @(negedge clk);
    end
    heldPast = !warmSysRstN;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int len, cnt;
    bit sm, sd, cd, hp;
    logic [3:0] f;
    logic [CNT_W-1:0] c;

    repeat (3) @(negedge clk);
    // R1: asserted state under cold reset
    chk(pinOe && !debugRstN && !coldSysRstN && !warmSysRstN, "R1 reset state",
        {pinOe, debugRstN, coldSysRstN, warmSysRstN}, 4'b1000);
    // R6: test reset low drives tap reset
    chk(!tapRstN, "R6 tap under test reset", tapRstN, 0);
    testRstN = 1'b1;
    porN = 1'b1;
    cnt = 0;
    @(negedge clk);
    while (pinOe && cnt < 5000) begin
      cnt++;
      if (coldSysRstN) cd = 0;
      @(negedge clk);
    end
    // R11/R2: post-cold pulse uses default count
    chk(cnt >= DEF && cnt <= DEF + 3, "R2 cold pulse length", cnt, DEF);
    chk(cfgFlagsOut == 4'd0 && cfgCountOut == 12'(DEF), "R2 cold defaults",
        cfgCountOut, DEF);
    repeat (5) @(negedge clk);
    chk(debugRstN && coldSysRstN && warmSysRstN && tapRstN, "R1 released",
        {debugRstN, coldSysRstN, warmSysRstN, tapRstN}, 4'b1111);
    chk(!safeReqMain && !safeReqDebug, "R9 no request after cold",
        {safeReqMain, safeReqDebug}, 0);

    for (int i = 0; i < 7; i++) begin
      f = VEC[i][17:14];
      c = VEC[i][13:2];
      writeCfg(f, c);
      chk(cfgFlagsOut == f && cfgCountOut == c, "R8 write visible", cfgFlagsOut, f);
      warmRun(len, sm, sd, cd, hp);
      chk(len == ((c == 0) ? 1 : int'(c)), "R3 pulse length", len, (c == 0) ? 1 : c);
      chk(hp, "R4 warm reset past pin release", !hp, 0);
      chk(sm == VEC[i][1], "R9 main safe request", sm, VEC[i][1]);
      chk(sd == VEC[i][0], "R10 debug safe request", sd, VEC[i][0]);
      chk(cd, "R5 cold domains immune", cd, 1);
      chk(tapRstN, "R6 tap immune to warm", tapRstN, 1);
      repeat (10) @(negedge clk);
      chk(!pinOe && warmSysRstN, "R7 no self retrigger", pinOe, 0);
      chk(cfgFlagsOut == f && cfgCountOut == c, "R8 settings survive warm",
          cfgFlagsOut, f);
    end

    // R6: cold reset does not touch tap reset; test reset is asynchronous
    #3 porN = 1'b0;
    #1;
    chk(!warmSysRstN && !debugRstN && pinOe, "R1 async cold assert",
        warmSysRstN, 0);
    chk(tapRstN, "R6 tap immune to cold", tapRstN, 1);
    @(negedge clk);
    porN = 1'b1;
    while (pinOe) @(negedge clk);
    repeat (5) @(negedge clk);
    #3 testRstN = 1'b0;
    #1;
    chk(!tapRstN && warmSysRstN, "R6 test reset async", tapRstN, 0);
    @(negedge clk);
    testRstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(tapRstN, "R6 tap release", tapRstN, 1);

    // R11: cold reset in the middle of a warm pulse
    writeCfg(4'b1011, 12'd40);
    extLow = 1'b1;
    repeat (2) @(negedge clk);
    extLow = 1'b0;
    while (!pinOe) @(negedge clk);
    repeat (10) @(negedge clk);
    porN = 1'b0;
    repeat (3) @(negedge clk);
    chk(cfgFlagsOut == 4'd0 && cfgCountOut == 12'(DEF), "R11 cold clears settings",
        cfgCountOut, DEF);
    porN = 1'b1;
    cnt = 0;
    @(negedge clk);
    while (pinOe && cnt < 5000) begin cnt++; @(negedge clk); end
    chk(cnt >= DEF && cnt <= DEF + 3, "R11 pulse restarts at default", cnt, DEF);
    chk(!coldSysRstN && !debugRstN, "R11 cold domains held through guard",
        coldSysRstN, 0);
    repeat (5) @(negedge clk);
    chk(coldSysRstN && debugRstN && warmSysRstN, "R11 domains released",
        coldSysRstN, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule